// File: doc/BRIEF.md
# Digital Microphone Capture Front End

This block receives a one-bit pulse-density stream from a single digital microphone and prepares it for the record path. It divides a fast system clock down to the microphone clock, with the ratio taken from the configured record sample-rate code. It resamples the data pin through a two-flop synchronizer and latches one bit per microphone clock period, at the exact middle of the high phase. Each captured bit leaves the block with a one-cycle strobe.

A select bit sets which source feeds the record path. When it is clear, the converter sample and its valid flag pass straight through. When it is set, the converter is cut off and the record path receives the captured bits as full-scale words. Volume is applied further down the record path by the gain stage that the converter path also uses.

A three-state machine drives the microphone clock. The states are `ST_IDLE` (clock low), `ST_HIGH` and `ST_LOW`. The transitions are START (`ST_IDLE`→`ST_HIGH`, the configuration is loaded), FALL (`ST_HIGH`→`ST_LOW`, after a full half period), RISE (`ST_LOW`→`ST_HIGH`, the configuration is reloaded for the next period) and STOP (`ST_LOW`→`ST_IDLE`, the run condition has gone). Configuration is read only at START and RISE, so a change always waits for the end of a complete period.

Top module: `dmic_capture_top`

## Requirements
- R1: While `dmic_en` is 0, `rec_in` equals `adc_in` and `rec_valid` equals `adc_valid` in the same cycle.
- R2: While `dmic_en` is 1, the converter is deselected. `rec_valid` is high only together with `bit_valid`. `rec_in` is 16'h7FFF for a captured 1 and 16'h8000 for a captured 0.
- R3: A new clock period starts only when `dmic_en`, `clk_out_en` and `rec_en` are all 1 and `rate_code` is not 0. Otherwise `dmic_clk` stays low and no `bit_valid` is issued.
- R4: The high phase and the low phase of `dmic_clk` each last H = 2*`rate_code` system clock cycles: 2, 4 or 6 cycles for codes 1, 2 and 3.
- R5: The bit captured in a period is the value on `dmic_data` at the system clock edge H/2 cycles after the edge that raised `dmic_clk`. Values at every other edge are ignored.
- R6: `bit_valid` is high for exactly one cycle per period. It rises at the edge H/2+2 cycles after the rising edge of `dmic_clk` and carries the captured bit on `bit_data`.
- R7: A change of `rate_code` during a period takes effect only at the next period. The current period keeps its old phase lengths.
- R8: If the run condition drops in the middle of a period, that period still completes with full-length phases. `dmic_clk` then stays low, and only that period's bit is strobed.
- R9: During and right after reset, `dmic_clk` and `bit_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dmic_en | input | 1 | Selects the microphone as the record-path source |
| clk_out_en | input | 1 | Enables the microphone clock output function |
| rec_en | input | 1 | Record path enabled |
| rate_code | input | RATE_W (2) | Record sample-rate code; 0 means no rate set |
| dmic_data | input | 1 | Asynchronous microphone data pin |
| adc_in | input | DATA_W (16) | Converter sample |
| adc_valid | input | 1 | Converter sample valid |
| dmic_clk | output | 1 | Microphone clock |
| bit_valid | output | 1 | One-cycle strobe for a captured bit |
| bit_data | output | 1 | Captured bit |
| rec_in | output | DATA_W (16) | Selected record-path input word |
| rec_valid | output | 1 | Selected record-path valid |

## Verification
A stuck or mis-sequenced state shows at once on `dmic_clk`: a phase that is too short or too long, or a clock that does not stop. The bench catches this within the first period it measures. A wrong sampling counter or a wrong synchronizer depth shifts the capture point by a cycle. The bench drives the correct bit only in the single cycle around the midpoint, so `bit_data` comes out inverted within one period. A configuration load that happens mid-period shows as a wrong phase length in that period. A mux fault shows on `rec_in` or `rec_valid` in the same cycle.

// File: rtl/dmic_pkg.sv
package dmic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } dmic_state_e;

endpackage

// File: rtl/dmic_sync.sv
module dmic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/dmic_clkgen.sv
module dmic_clkgen
    import dmic_pkg::*;
#(
    parameter int HALF_BASE   = 2,
    parameter int RATE_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_code,
    output logic              mic_clk,
    output logic              cap_hit
);

    localparam int MAX_HALF = HALF_BASE * ((1 << RATE_W) - 1);
    localparam int HALF_W   = $clog2(MAX_HALF + 1);

    dmic_state_e       state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] half_q, half_new;
    logic [HALF_W-1:0] capcnt_q, capcnt_new;
    logic              caplow_q, caplow_new;
    logic              load;
    logic              last;
    int                half_i;
    int                tgt_i;

    // Phase length and capture position for the configuration now on the inputs.
    always_comb begin
        half_i     = HALF_BASE * int'(rate_code);
        tgt_i      = half_i / 2 + SYNC_STAGES - 1;
        half_new   = HALF_W'(half_i);
        caplow_new = (tgt_i >= half_i);
        capcnt_new = caplow_new ? HALF_W'(tgt_i - half_i) : HALF_W'(tgt_i);
    end

    assign last = (cnt_q == (half_q - HALF_W'(1)));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (run) begin                   // START
                    load    = 1'b1;
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (last) begin                  // FALL
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            ST_LOW: begin
                if (last) begin
                    cnt_d = '0;
                    if (run) begin               // RISE
                        load    = 1'b1;
                        state_d = ST_HIGH;
                    end else begin               // STOP
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            half_q   <= HALF_W'(HALF_BASE);
            capcnt_q <= '0;
            caplow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                half_q   <= half_new;
                capcnt_q <= capcnt_new;
                caplow_q <= caplow_new;
            end
        end
    end

    // Outputs.
    always_comb begin
        mic_clk = 1'b0;
        cap_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mic_clk = 1'b0;
                cap_hit = 1'b0;
            end
            ST_HIGH: begin
                mic_clk = 1'b1;
                cap_hit = !caplow_q && (cnt_q == capcnt_q);
            end
            ST_LOW: begin
                mic_clk = 1'b0;
                cap_hit = caplow_q && (cnt_q == capcnt_q);
            end
            default: begin
                mic_clk = 1'b0;
                cap_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dmic_sampler.sv
module dmic_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_hit,
    input  logic din_sync,
    output logic bit_valid,
    output logic bit_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= cap_hit;
            if (cap_hit) bit_data <= din_sync;
        end
    end

endmodule

// File: rtl/dmic_recmux.sv
module dmic_recmux #(
    parameter int DATA_W = 16
) (
    input  logic              mic_sel,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic [DATA_W-1:0] adc_in,
    input  logic              adc_valid,
    output logic [DATA_W-1:0] rec_in,
    output logic              rec_valid
);

    localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        if (mic_sel) begin
            rec_valid = bit_valid;
            if (bit_valid) rec_in = bit_data ? POS_FS : NEG_FS;
            else           rec_in = '0;
        end else begin
            rec_valid = adc_valid;
            rec_in    = adc_in;
        end
    end

endmodule

// File: rtl/dmic_capture_top.sv
module dmic_capture_top #(
    parameter int DATA_W      = 16,
    parameter int RATE_W      = 2,
    parameter int HALF_BASE   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmic_en,
    input  logic              clk_out_en,
    input  logic              rec_en,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              dmic_data,
    input  logic [DATA_W-1:0] adc_in,
    input  logic              adc_valid,
    output logic              dmic_clk,
    output logic              bit_valid,
    output logic              bit_data,
    output logic [DATA_W-1:0] rec_in,
    output logic              rec_valid
);

    logic run;
    logic data_sync;
    logic cap_hit;

    assign run = dmic_en && clk_out_en && rec_en && (rate_code != '0);

    dmic_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dmic_data),
        .dout  (data_sync)
    );

    dmic_clkgen #(
        .HALF_BASE   (HALF_BASE),
        .RATE_W      (RATE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rate_code (rate_code),
        .mic_clk   (dmic_clk),
        .cap_hit   (cap_hit)
    );

    dmic_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_hit   (cap_hit),
        .din_sync  (data_sync),
        .bit_valid (bit_valid),
        .bit_data  (bit_data)
    );

    dmic_recmux #(
        .DATA_W (DATA_W)
    ) u_recmux (
        .mic_sel   (dmic_en),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .adc_in    (adc_in),
        .adc_valid (adc_valid),
        .rec_in    (rec_in),
        .rec_valid (rec_valid)
    );

endmodule

module dmic_capture_chk #(
    parameter int DATA_W = 16,
    parameter int RATE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dmic_en,
    input logic              clk_out_en,
    input logic              rec_en,
    input logic [RATE_W-1:0] rate_code,
    input logic [DATA_W-1:0] adc_in,
    input logic              adc_valid,
    input logic              dmic_clk,
    input logic              bit_valid,
    input logic [DATA_W-1:0] rec_in,
    input logic              rec_valid
);

    logic run_cond;
    assign run_cond = dmic_en && clk_out_en && rec_en && (rate_code != '0);

    // R1
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dmic_en |-> (rec_in == adc_in && rec_valid == adc_valid));

    // R2
    adc_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmic_en && !bit_valid) |-> !rec_valid);

    // R3
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmic_clk) |-> $past(run_cond));

    // R4
    no_runt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmic_clk) |=> dmic_clk);

    // R4
    no_runt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmic_clk) |=> !dmic_clk);

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

endmodule

bind dmic_capture_top dmic_capture_chk #(
    .DATA_W (DATA_W),
    .RATE_W (RATE_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dmic_en    (dmic_en),
    .clk_out_en (clk_out_en),
    .rec_en     (rec_en),
    .rate_code  (rate_code),
    .adc_in     (adc_in),
    .adc_valid  (adc_valid),
    .dmic_clk   (dmic_clk),
    .bit_valid  (bit_valid),
    .rec_in     (rec_in),
    .rec_valid  (rec_valid)
);

// File: tb/test_dmic_capture_top.sv
module test_dmic_capture_top;

    localparam int DATA_W = 16;
    localparam int RATE_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dmic_en = 1'b0;
    logic              clk_out_en = 1'b0;
    logic              rec_en = 1'b0;
    logic [RATE_W-1:0] rate_code = '0;
    logic              dmic_data = 1'b0;
    logic [DATA_W-1:0] adc_in = '0;
    logic              adc_valid = 1'b0;
    logic              dmic_clk;
    logic              bit_valid;
    logic              bit_data;
    logic [DATA_W-1:0] rec_in;
    logic              rec_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dmic_capture_top i_dmic_capture_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .dmic_en    (dmic_en),
        .clk_out_en (clk_out_en),
        .rec_en     (rec_en),
        .rate_code  (rate_code),
        .dmic_data  (dmic_data),
        .adc_in     (adc_in),
        .adc_valid  (adc_valid),
        .dmic_clk   (dmic_clk),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .rec_in     (rec_in),
        .rec_valid  (rec_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        int   guard;
        prev  = dmic_clk;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (dmic_clk && !prev) break;
            prev = dmic_clk;
            if (guard > 200) begin
                check(1'b0, "R3 clock did not start", 0, 1);
                break;
            end
        end
    endtask

    task automatic count_run(input logic lvl, output int n);
        n = 0;
        while (dmic_clk == lvl && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stop_all();
        dmic_en = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        check(dmic_clk == 1'b0, "R9 dmic_clk in reset", dmic_clk, 0);
        check(bit_valid == 1'b0, "R9 bit_valid in reset", bit_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dmic_clk == 1'b0 && bit_valid == 1'b0, "R9 outputs after reset",
              {dmic_clk, bit_valid}, 0);
    endtask

    task automatic t_bypass();
        int bad;
        bad = 0;
        dmic_en = 1'b0; clk_out_en = 1'b1; rec_en = 1'b1; rate_code = 2'd1;
        for (int i = 0; i < 20; i++) begin
            adc_in    = DATA_W'(16'h1234 + i * 97);
            adc_valid = i[0];
            @(negedge clk);
            if (rec_in != adc_in || rec_valid != adc_valid) bad++;
            if (dmic_clk || bit_valid) bad++;
        end
        check(bad == 0, "R1 converter passthrough", bad, 0);
    endtask

    task automatic t_gating();
        int clk_hi, strobes, recv;
        adc_valid = 1'b1;
        adc_in    = 16'h0ABC;
        for (int mode = 0; mode < 3; mode++) begin
            dmic_en    = 1'b1;
            clk_out_en = (mode != 0);
            rec_en     = (mode != 1);
            rate_code  = (mode == 2) ? 2'd0 : 2'd2;
            clk_hi = 0; strobes = 0; recv = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                clk_hi  += dmic_clk;
                strobes += bit_valid;
                recv    += rec_valid;
            end
            check(clk_hi == 0, "R3 clock held low when not running", clk_hi, 0);
            check(strobes == 0, "R3 no strobes when not running", strobes, 0);
            check(recv == 0, "R2 converter deselected", recv, 0);
        end
        dmic_en = 1'b0;
    endtask

    task automatic t_capture(input int code);
        int   h, nh, nl;
        logic b;
        h = 2 * code;
        adc_valid = 1'b1;
        dmic_en = 1'b1; clk_out_en = 1'b1; rec_en = 1'b1;
        rate_code = RATE_W'(code);
        for (int p = 0; p < 6; p++) begin
            b = ((6'b101100 >> p) & 1) ^ code[0];
            wait_rise();
            for (int k = 0; k <= h / 2 + 2; k++) begin
                if (k == 0) dmic_data = ~b;
                if (k == h / 2 - 1) dmic_data = b;
                if (k == h / 2) dmic_data = ~b;
                if (k == h / 2 + 1) begin
                    check(bit_valid == 1'b0, "R6 no early strobe", bit_valid, 0);
                    check(rec_valid == 1'b0, "R2 rec_valid only with strobe", rec_valid, 0);
                end
                if (k == h / 2 + 2) begin
                    check(bit_valid == 1'b1, "R6 strobe position", bit_valid, 1);
                    check(bit_data == b, "R5 midpoint bit", bit_data, b);
                    check(rec_valid == 1'b1 &&
                          rec_in == (b ? 16'h7FFF : 16'h8000),
                          "R2 full-scale word", rec_in, b ? 16'h7FFF : 16'h8000);
                end
                if (k < h / 2 + 2) @(negedge clk);
            end
        end
        wait_rise();
        count_run(1'b1, nh);
        count_run(1'b0, nl);
        check(nh == h, "R4 high phase length", nh, h);
        check(nl == h, "R4 low phase length", nl, h);
        stop_all();
    endtask

    task automatic t_rate_change();
        int n;
        dmic_en = 1'b1; clk_out_en = 1'b1; rec_en = 1'b1; rate_code = 2'd1;
        wait_rise();
        rate_code = 2'd3;
        count_run(1'b1, n);
        check(n == 2, "R7 current high keeps old length", n, 2);
        count_run(1'b0, n);
        check(n == 2, "R7 current low keeps old length", n, 2);
        count_run(1'b1, n);
        check(n == 6, "R7 next high uses new length", n, 6);
        count_run(1'b0, n);
        check(n == 6, "R7 next low uses new length", n, 6);
        stop_all();
    endtask

    task automatic t_disable_mid();
        int n, lows, strobes;
        dmic_en = 1'b1; clk_out_en = 1'b1; rec_en = 1'b1; rate_code = 2'd2;
        wait_rise();
        @(negedge clk);
        rec_en = 1'b0;
        count_run(1'b1, n);
        check(n == 3, "R8 high phase completes", n, 3);
        lows = 0; strobes = 0;
        for (int i = 0; i < 30; i++) begin
            lows    += !dmic_clk;
            strobes += bit_valid;
            @(negedge clk);
        end
        check(lows == 30, "R8 clock stays low after stop", lows, 30);
        check(strobes == 1, "R8 only last period strobed", strobes, 1);
        stop_all();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_bypass();
        t_gating();
        t_capture(1);
        t_capture(2);
        t_capture(3);
        t_rate_change();
        t_disable_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule